// File: doc/BRIEF.md
# Cascaded Quadrature Position Counter

This block turns the two phase signals of an incremental encoder into a signed 32-bit position. Each legal edge on either phase moves the position by one, so one full encoder line gives four counts. The position is held in two 16-bit words. The low word counts every step. The high word is a separate up/down counter. It moves only when the low word rolls over, and the direction of the step that caused the rollover sets which way it moves.

Two separate counters create a risk of torn reads. A reader that fetches the words at different times can be off by exactly 2^16 if the low word rolls over between the two reads. To avoid this, a one-cycle snapshot request copies both words into a 32-bit holding register on the same clock edge. Counting continues during the capture. The copy includes any step that is counted on that edge.

The phase pins pass through a two-flop synchronizer. A transition in which both phases change at once is rejected and reported. An enable input pauses counting, but the decoder keeps following the phase state while paused.

Top module: `quad_pos_counter`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `snap_pos_o` is 0 and `snap_valid_o`, `wrap_o` and `quad_err_o` are 0.
- R2: Take {phase_a, phase_b} as a two-bit state. The forward order is 00, 01, 11, 10, 00. Each step forward adds one to the position and each step backward subtracts one, so one full cycle gives four counts.
- R3: Bits 15:0 of the position are the low counter, which wraps modulo 2^16.
- R4: `wrap_o` is a one-cycle pulse. It fires when a forward step takes the low word from 0xFFFF to 0x0000, or when a backward step takes it from 0x0000 to 0xFFFF. While it is high, `dir_o` is 1 for a forward step and 0 for a backward step.
- R5: The high word changes only on a wrap: +1 on a forward wrap and −1 on a backward wrap. {high, low} is the two's-complement position modulo 2^32.
- R6: A request sampled on edge k loads the post-edge value of both words into `snap_pos_o` on that same edge. `snap_valid_o` is high for exactly the next cycle. `snap_pos_o` holds its value until the next capture.
- R7: If a capture falls on the same edge as a wrap, both words come from after the wrap. The result is never off by 2^16.
- R8: A transition in which both phases change together leaves the position unchanged and gives a one-cycle `quad_err_o` pulse. The new state becomes the reference for the next step.
- R9: While `enable_i` is low, neither word changes. Phase changes made while paused cause no count when counting resumes.
- R10: A phase change that is present before edge k is counted on edge k+2, which is the result of the two synchronizer stages. A capture on edge k+1 excludes it and a capture on edge k+2 includes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| phase_a_i | input | 1 | Encoder phase A (asynchronous) |
| phase_b_i | input | 1 | Encoder phase B (asynchronous) |
| enable_i | input | 1 | Count enable |
| snap_req_i | input | 1 | One-cycle capture request |
| snap_pos_o | output | 32 | Captured position {high, low} |
| snap_valid_o | output | 1 | Pulse one cycle after a capture |
| dir_o | output | 1 | Direction of the last counted step (1 = forward) |
| wrap_o | output | 1 | Low-word rollover pulse |
| quad_err_o | output | 1 | Illegal double-phase transition pulse |

## Verification
The assertions check these properties on every cycle:
- The low word moves by at most one per cycle.
- The high word changes exactly when `wrap_o` is high.
- Each `wrap_o` pulse leaves the low word at the rollover value that matches `dir_o`.
- Nothing counts while paused or on an illegal transition.
- Every valid snapshot equals the live pair of words.

Other behaviours need the bench's scenarios:
- The two-cycle input latency.
- The phase order that defines forward.
- Captures that land exactly on a rollover edge.
- The absence of phantom counts after a pause.

Those scenarios compare each capture against an arithmetic 32-bit model across forward, backward and random walks through several rollovers.

// File: rtl/qpc_pkg.sv
package qpc_pkg;

  typedef enum logic [1:0] {
    STEP_NONE = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2,
    STEP_BAD  = 2'd3
  } qpc_step_e;

  // Gray phase state to its position in the forward cycle 00,01,11,10
  function automatic logic [1:0] phase_to_idx(input logic [1:0] ph);
    return {ph[1], ph[1] ^ ph[0]};
  endfunction

endpackage

// File: rtl/qpc_sync.sv
module qpc_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [WIDTH-1:0] stage_d;
    if (s == 0) begin : g_first
      assign stage_d = d_i;
    end else begin : g_next
      assign stage_d = stage_q[s-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else         stage_q[s] <= stage_d;
    end
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/qpc_decoder.sv
module qpc_decoder
  import qpc_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic [1:0] phase_i,
  output qpc_step_e step_o
);

  logic [1:0] ref_q;
  logic [1:0] delta;

  always_comb begin
    delta = phase_to_idx(phase_i) - phase_to_idx(ref_q);
    unique case (delta)
      2'd1:    step_o = STEP_UP;
      2'd3:    step_o = STEP_DOWN;
      2'd2:    step_o = STEP_BAD;
      default: step_o = STEP_NONE;
    endcase
  end

  // Reference always follows the observed state, even for rejected steps
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ref_q <= 2'b00;
    else         ref_q <= phase_i;
  end

endmodule

// File: rtl/qpc_updown.sv
module qpc_updown #(
  parameter int WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cnt_en_i,
  input  logic             up_i,
  output logic [WIDTH-1:0] cnt_q_o,
  output logic [WIDTH-1:0] cnt_d_o,
  output logic             wrap_o
);

  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  logic [WIDTH-1:0] cnt_q;
  logic [WIDTH-1:0] cnt_d;

  always_comb begin
    cnt_d  = cnt_q;
    wrap_o = 1'b0;
    if (cnt_en_i) begin
      if (up_i) begin
        cnt_d  = cnt_q + ONE;
        wrap_o = (cnt_q == '1);
      end else begin
        cnt_d  = cnt_q - ONE;
        wrap_o = (cnt_q == '0);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (cnt_en_i) cnt_q <= cnt_d;
  end

  assign cnt_q_o = cnt_q;
  assign cnt_d_o = cnt_d;

endmodule

// File: rtl/quad_pos_counter.sv
module quad_pos_counter
  import qpc_pkg::*;
#(
  parameter int LO_W        = 16,
  parameter int HI_W        = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 phase_a_i,
  input  logic                 phase_b_i,
  input  logic                 enable_i,
  input  logic                 snap_req_i,
  output logic [LO_W+HI_W-1:0] snap_pos_o,
  output logic                 snap_valid_o,
  output logic                 dir_o,
  output logic                 wrap_o,
  output logic                 quad_err_o
);

  localparam int POS_W = LO_W + HI_W;

  logic [1:0]      phase_s;
  qpc_step_e       step;
  logic            step_en;
  logic            step_up;
  logic [LO_W-1:0] lo_q, lo_d;
  logic [HI_W-1:0] hi_q, hi_d;
  logic            lo_wrap;
  logic            hi_wrap_unused;

  qpc_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({phase_a_i, phase_b_i}),
    .q_o    (phase_s)
  );

  qpc_decoder u_dec (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .phase_i (phase_s),
    .step_o  (step)
  );

  assign step_up = (step == STEP_UP);
  assign step_en = enable_i && (step == STEP_UP || step == STEP_DOWN);

  qpc_updown #(.WIDTH(LO_W)) u_lo (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cnt_en_i (step_en),
    .up_i     (step_up),
    .cnt_q_o  (lo_q),
    .cnt_d_o  (lo_d),
    .wrap_o   (lo_wrap)
  );

  // High word strobed only by low-word rollover, steered by step direction
  qpc_updown #(.WIDTH(HI_W)) u_hi (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cnt_en_i (lo_wrap),
    .up_i     (step_up),
    .cnt_q_o  (hi_q),
    .cnt_d_o  (hi_d),
    .wrap_o   (hi_wrap_unused)
  );

  // Output and capture registers: next-state logic
  logic [POS_W-1:0] snap_q, snap_d;
  logic             valid_q, dir_q, dir_d, wrap_q, err_q;

  always_comb begin
    snap_d = snap_q;
    if (snap_req_i) snap_d = {hi_d, lo_d};
    dir_d = dir_q;
    if (step_en) dir_d = step_up;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      snap_q  <= '0;
      valid_q <= 1'b0;
      dir_q   <= 1'b0;
      wrap_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      snap_q  <= snap_d;
      valid_q <= snap_req_i;
      dir_q   <= dir_d;
      wrap_q  <= lo_wrap;
      err_q   <= (step == STEP_BAD);
    end
  end

  assign snap_pos_o   = snap_q;
  assign snap_valid_o = valid_q;
  assign dir_o        = dir_q;
  assign wrap_o       = wrap_q;
  assign quad_err_o   = err_q;

endmodule

// File: rtl/qpc_checker.sv
module qpc_checker #(
  parameter int LO_W = 16,
  parameter int HI_W = 16
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 enable_i,
  input logic [LO_W-1:0]      lo_i,
  input logic [HI_W-1:0]      hi_i,
  input logic                 wrap_i,
  input logic                 dir_i,
  input logic                 err_i,
  input logic                 snap_valid_i,
  input logic [LO_W+HI_W-1:0] snap_pos_i
);

  // R2
  lo_single_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lo_i == $past(lo_i)) || (lo_i == LO_W'($past(lo_i) + 1'b1)) ||
    (lo_i == LO_W'($past(lo_i) - 1'b1)));

  // R4
  wrap_fwd_value_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap_i && dir_i) |-> (lo_i == '0));

  // R4
  wrap_bwd_value_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap_i && !dir_i) |-> (lo_i == '1));

  // R5
  hi_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wrap_i |-> (hi_i == $past(hi_i)));

  // R5
  hi_move_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_i |-> (hi_i == (dir_i ? HI_W'($past(hi_i) + 1'b1) : HI_W'($past(hi_i) - 1'b1))));

  // R6
  snap_coherent_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snap_valid_i |-> (snap_pos_i == {hi_i, lo_i}));

  // R6
  snap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !snap_valid_i |-> $stable(snap_pos_i));

  // R8
  bad_no_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_i |-> (lo_i == $past(lo_i)) && !wrap_i);

  // R9
  paused_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(enable_i) |-> (lo_i == $past(lo_i)) && (hi_i == $past(hi_i)));

endmodule

bind quad_pos_counter qpc_checker #(.LO_W(LO_W), .HI_W(HI_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .enable_i     (enable_i),
  .lo_i         (lo_q),
  .hi_i         (hi_q),
  .wrap_i       (wrap_o),
  .dir_i        (dir_o),
  .err_i        (quad_err_o),
  .snap_valid_i (snap_valid_o),
  .snap_pos_i   (snap_pos_o)
);

// File: tb/quad_pos_counter_test.sv
module quad_pos_counter_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        pa, pb, en, sreq;
  logic [31:0] snap_pos;
  logic        snap_valid, dir, wrap, qerr;

  always #5 clk = ~clk;

  quad_pos_counter uut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .phase_a_i    (pa),
    .phase_b_i    (pb),
    .enable_i     (en),
    .snap_req_i   (sreq),
    .snap_pos_o   (snap_pos),
    .snap_valid_o (snap_valid),
    .dir_o        (dir),
    .wrap_o       (wrap),
    .quad_err_o   (qerr)
  );

  int n_vec = 0;
  int n_bad = 0;

  // Model history: index 0 = latest applied step, 2 = two steps older
  logic [31:0] h0 = '0, h1 = '0, h2 = '0;
  bit w0 = 0, w1 = 0, w2 = 0;
  bit u0 = 0, u1 = 0, u2 = 0;
  bit e0 = 0, e1 = 0, e2 = 0;
  int idx = 0;
  bit pend = 0;
  logic [31:0] pend_exp;
  string pend_tag;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=0x%08h expected=0x%08h", req, what, act, exp);
    end
  endtask

  task automatic run_step(input int d, input bit snap, input bit cnt, input string tag);
    logic [31:0] nh;
    bit nw, nu, ne;
    @(negedge clk);
    if (pend) begin
      chk("R6", "snap_valid", {31'd0, snap_valid}, 32'd1);
      chk(pend_tag, "snapshot", snap_pos, pend_exp);
      pend = 0;
    end else begin
      chk("R6", "snap_valid idle", {31'd0, snap_valid}, 32'd0);
    end
    chk("R4", "wrap pulse", {31'd0, wrap}, {31'd0, w2});
    if (w2) chk("R4", "wrap direction", {31'd0, dir}, {31'd0, u2});
    chk("R8", "error pulse", {31'd0, qerr}, {31'd0, e2});
    nh = h0; nw = 0; nu = u0; ne = 0;
    if (d == 2) begin
      idx = (idx + 2) & 3;
      ne  = 1;
    end else if (d != 0) begin
      idx = (idx + d) & 3;
      if (cnt) begin
        nw = (d > 0) ? (h0[15:0] == 16'hFFFF) : (h0[15:0] == 16'h0000);
        nh = h0 + 32'(d);
        nu = (d > 0);
      end
    end
    h2 = h1; h1 = h0; h0 = nh;
    w2 = w1; w1 = w0; w0 = nw;
    u2 = u1; u1 = u0; u0 = nu;
    e2 = e1; e1 = e0; e0 = ne;
    pa = idx[1];
    pb = idx[1] ^ idx[0];
    sreq = snap;
    if (snap) begin
      pend = 1;
      pend_exp = h2;
      pend_tag = tag;
    end
  endtask

  function automatic bit near_wrap(input logic [31:0] p);
    return (p[15:0] >= 16'hFFF8) || (p[15:0] <= 16'h0008);
  endfunction

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL R1..R10 watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; pa = 1'b0; pb = 1'b0; en = 1'b1; sreq = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "snap_pos in reset", snap_pos, 32'd0);
    chk("R1", "valid/wrap/err in reset", {29'd0, snap_valid, wrap, qerr}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "snap_pos after reset", snap_pos, 32'd0);
    chk("R1", "flags after reset", {29'd0, snap_valid, wrap, qerr}, 32'd0);

    // R10 latency: capture one and two edges after a phase change
    run_step(1, 1, 1, "R10");
    run_step(0, 1, 1, "R10");
    run_step(0, 1, 1, "R10");
    run_step(0, 1, 1, "R10");

    // R2 forward order and reverse
    for (int i = 0; i < 8; i++) run_step(1, (i % 2) == 1, 1, "R2");
    for (int i = 0; i < 4; i++) run_step(-1, 1, 1, "R2");

    // R5 backward across zero: negative positions in two's complement
    for (int i = 0; i < 20; i++) run_step(-1, 1, 1, "R5");

    // R3/R7 forward sweep through a low-word rollover
    while ($signed(h0) < 66000) begin
      if (near_wrap(h0)) run_step(1, 1, 1, "R7");
      else               run_step(1, h0[9:0] == 10'd0, 1, "R3");
    end

    // Return close to the rollover, then a random walk across it (R7, R8)
    for (int i = 0; i < 470; i++) run_step(-1, (i % 16) == 0, 1, "R5");
    for (int i = 0; i < 4000; i++) begin
      int r;
      int d;
      r = int'($urandom % 50);
      d = (r == 0) ? 2 : (r < 17) ? -1 : (r < 34) ? 1 : 0;
      run_step(d, near_wrap(h0) || ($urandom % 8 == 0), 1, (d == 2) ? "R8" : "R7");
    end
    run_step(2, 0, 1, "R8");
    run_step(1, 0, 1, "R8");
    for (int i = 0; i < 3; i++) run_step(0, 1, 1, "R8");

    // R9 pause: steps while disabled are tracked but not counted
    en = 1'b0;
    for (int i = 0; i < 3; i++) run_step(0, 0, 1, "R9");
    for (int i = 0; i < 6; i++) run_step(1, 1, 0, "R9");
    for (int i = 0; i < 3; i++) run_step(-1, 1, 0, "R9");
    for (int i = 0; i < 3; i++) run_step(0, 0, 0, "R9");
    en = 1'b1;
    for (int i = 0; i < 3; i++) run_step(0, 1, 1, "R9");
    run_step(1, 0, 1, "R9");
    for (int i = 0; i < 3; i++) run_step(0, 1, 1, "R9");

    // R5 long backward sweep across two rollovers into negative range
    while ($signed(h0) > -2000) begin
      if (near_wrap(h0)) run_step(-1, 1, 1, "R7");
      else               run_step(-1, h0[10:0] == 11'd0, 1, "R5");
    end
    for (int i = 0; i < 4; i++) run_step(0, 1, 1, "R5");
    run_step(0, 0, 1, "R6");
    finish_run();
  end

endmodule